// File: doc/BRIEF.md
# Host Download Bootstrap Loader

After reset, this block takes a program image from a host over a byte-wide write port and writes it into on-chip program memory one 24-bit word at a time. The host sends each word as three byte writes. The high and middle bytes are held in staging registers. Writing the low byte writes the complete word to program memory at the current load address, and that address then steps by one.

Loading ends in one of two ways. The first is when the load address reaches the image size `WORDS`. The second is earlier, when the host writes the control register with the release flag set. In both cases the block raises a sticky run output for the processor core. It also presents two start values: an address-register value equal to the number of words loaded, and an operating-mode value. After release, host data writes no longer reach program memory.

Top module: `host_boot_loader`

## Requirements
- R1: While `core_run` is low, a host write with `hb_sel`=3 (low byte) raises `pm_we` for that same cycle only. During that cycle `pm_wdata` is {high staging byte, middle staging byte, `hb_data`} and `pm_addr` is the current load address. The load address is one higher in the following cycle.
- R2: Reset is synchronous and active high. It sets the load address to 0, drives `core_run` low, and sets `start_addr` and `mode_out` to 0.
- R3: The low-byte write that stores word number `WORDS`-1 sets `core_run` on the next clock edge. Every earlier word leaves `core_run` low.
- R4: When loading ends, `start_addr` takes the number of words stored so far and `mode_out` takes `RUN_MODE` (default 2). Both change in the same cycle that `core_run` rises.
- R5: A host write with `hb_sel`=0 (control), while not running, ends loading at once if `hb_data` bit `FLAG_BIT` (default 3) is set. It has no effect if that bit is clear.
- R6: Once `core_run` is high, low-byte writes never raise `pm_we`.
- R7: Writes with `hb_sel`=1 (high) or 2 (middle) only load the staging registers and never raise `pm_we`. The staged bytes persist, so a low-byte write on its own reuses them.
- R8: `core_run` stays high until reset. After release, further control or data writes do not change `start_addr` or `mode_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_wr | input | 1 | Host byte write strobe, one cycle per byte |
| hb_sel | input | 2 | Byte select: 0 control, 1 high, 2 middle, 3 low |
| hb_data | input | 8 | Host byte value |
| pm_we | output | 1 | Program memory write enable |
| pm_addr | output | AW | Program memory word address |
| pm_wdata | output | 24 | Program memory write data |
| core_run | output | 1 | Release signal for the processor core |
| start_addr | output | CNT_W | Start value for the core's address register (words loaded) |
| mode_out | output | MODE_W | Start operating-mode value |

## Verification
The bench builds the block with `WORDS`=16 in place of the default 512. With that size, a full image download and its natural end are reached in a few hundred cycles. The other parameters keep their defaults, so the release flag is bit 3 and the start mode is 2. Early release is exercised after six words, which checks that the start address reports a partial count. A second run, after a fresh reset, loads the full image and shows the wrap from the last address to release.

// File: rtl/hbl_pkg.sv
package hbl_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_HI   = 2'd1,
    SEL_MID  = 2'd2,
    SEL_LO   = 2'd3
  } hbl_sel_e;

  localparam int unsigned WORD_W = 24;
  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/hbl_stage.sv
module hbl_stage
  import hbl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              hb_wr,
  input  logic [1:0]        hb_sel,
  input  logic [BYTE_W-1:0] hb_data,
  output logic [WORD_W-1:0] word
);
  logic [BYTE_W-1:0] hi_q;
  logic [BYTE_W-1:0] mid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q  <= '0;
      mid_q <= '0;
    end else if (hb_wr) begin
      if (hbl_sel_e'(hb_sel) == SEL_HI)  hi_q  <= hb_data;
      if (hbl_sel_e'(hb_sel) == SEL_MID) mid_q <= hb_data;
    end
  end

  assign word = {hi_q, mid_q, hb_data};
endmodule

// File: rtl/hbl_counter.sv
module hbl_counter #(
  parameter int unsigned WORDS = 512,
  parameter int unsigned CNT_W = $clog2(WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_next,
  output logic             at_last
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign count_next = cnt_q + CNT_W'(1);
  assign at_last    = (cnt_q == LAST);
  assign count      = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (step) cnt_q <= count_next;
  end
endmodule

// File: rtl/hbl_release.sv
module hbl_release #(
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned MODE_W   = 3,
  parameter int unsigned RUN_MODE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              end_full,
  input  logic              end_flag,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  count_next,
  output logic              run,
  output logic [CNT_W-1:0]  start_addr,
  output logic [MODE_W-1:0] mode_out
);
  logic              run_q;
  logic [CNT_W-1:0]  start_q;
  logic [MODE_W-1:0] mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      start_q <= '0;
      mode_q  <= '0;
    end else if (!run_q && (end_full || end_flag)) begin
      run_q   <= 1'b1;
      start_q <= end_full ? count_next : count;
      mode_q  <= MODE_W'(RUN_MODE);
    end
  end

  assign run        = run_q;
  assign start_addr = start_q;
  assign mode_out   = mode_q;
endmodule

// File: rtl/host_boot_loader.sv
module host_boot_loader
  import hbl_pkg::*;
#(
  parameter int unsigned WORDS    = 512,
  parameter int unsigned FLAG_BIT = 3,
  parameter int unsigned RUN_MODE = 2,
  parameter int unsigned MODE_W   = 3,
  parameter int unsigned AW       = $clog2(WORDS),
  parameter int unsigned CNT_W    = $clog2(WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hb_wr,
  input  logic [1:0]        hb_sel,
  input  logic [7:0]        hb_data,
  output logic              pm_we,
  output logic [AW-1:0]     pm_addr,
  output logic [23:0]       pm_wdata,
  output logic              core_run,
  output logic [CNT_W-1:0]  start_addr,
  output logic [MODE_W-1:0] mode_out
);
  logic             lo_commit;
  logic             flag_hit;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_next;
  logic             at_last;
  logic             run_i;

  assign lo_commit = hb_wr && (hbl_sel_e'(hb_sel) == SEL_LO) && !run_i;
  assign flag_hit  = hb_wr && (hbl_sel_e'(hb_sel) == SEL_CTRL) && hb_data[FLAG_BIT] && !run_i;

  hbl_stage u_stage (
    .clk     (clk),
    .rst     (rst),
    .hb_wr   (hb_wr),
    .hb_sel  (hb_sel),
    .hb_data (hb_data),
    .word    (pm_wdata)
  );

  hbl_counter #(.WORDS(WORDS), .CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .step       (lo_commit),
    .count      (cnt),
    .count_next (cnt_next),
    .at_last    (at_last)
  );

  hbl_release #(.CNT_W(CNT_W), .MODE_W(MODE_W), .RUN_MODE(RUN_MODE)) u_rel (
    .clk        (clk),
    .rst        (rst),
    .end_full   (lo_commit && at_last),
    .end_flag   (flag_hit),
    .count      (cnt),
    .count_next (cnt_next),
    .run        (run_i),
    .start_addr (start_addr),
    .mode_out   (mode_out)
  );

  assign pm_we    = lo_commit;
  assign pm_addr  = cnt[AW-1:0];
  assign core_run = run_i;
endmodule

// File: rtl/hbl_checker.sv
module hbl_checker #(
  parameter int unsigned WORDS    = 512,
  parameter int unsigned RUN_MODE = 2,
  parameter int unsigned MODE_W   = 3,
  parameter int unsigned AW       = 9,
  parameter int unsigned CNT_W    = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              hb_wr,
  input logic [1:0]        hb_sel,
  input logic              pm_we,
  input logic [AW-1:0]     pm_addr,
  input logic              core_run,
  input logic [CNT_W-1:0]  start_addr,
  input logic [MODE_W-1:0] mode_out
);
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    pm_we |=> (core_run || (pm_addr == ($past(pm_addr) + AW'(1))))); // R1
  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (pm_addr == '0 && !core_run && start_addr == '0 && mode_out == '0)); // R2
  AST_START_VALUES: assert property (@(posedge clk) disable iff (rst)
    $rose(core_run) |-> (mode_out == MODE_W'(RUN_MODE) && start_addr <= CNT_W'(WORDS))); // R4
  AST_NO_LOAD_RUNNING: assert property (@(posedge clk) disable iff (rst)
    core_run |-> !pm_we); // R6
  AST_STAGE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (hb_wr && (hb_sel == 2'd1 || hb_sel == 2'd2)) |-> !pm_we); // R7
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    core_run |=> (core_run && $stable(start_addr) && $stable(mode_out))); // R8
endmodule

bind host_boot_loader hbl_checker #(
  .WORDS(WORDS), .RUN_MODE(RUN_MODE), .MODE_W(MODE_W), .AW(AW), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .hb_wr(hb_wr), .hb_sel(hb_sel), .pm_we(pm_we),
  .pm_addr(pm_addr), .core_run(core_run), .start_addr(start_addr), .mode_out(mode_out)
);

// File: tb/sim_host_boot_loader.sv
`timescale 1ns/1ps
module sim_host_boot_loader;
  localparam int unsigned WORDS = 16;
  localparam int unsigned AW    = $clog2(WORDS);
  localparam int unsigned CNT_W = $clog2(WORDS + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hb_wr = 1'b0;
  logic [1:0] hb_sel = 2'd0;
  logic [7:0] hb_data = 8'd0;
  logic pm_we;
  logic [AW-1:0] pm_addr;
  logic [23:0] pm_wdata;
  logic core_run;
  logic [CNT_W-1:0] start_addr;
  logic [2:0] mode_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [AW+23:0] sb_q[$];
  int  exp_addr = 0;
  bit  exp_run = 1'b0;
  logic [7:0] exp_hi = 8'd0;
  logic [7:0] exp_mid = 8'd0;

  always #2 clk = ~clk;

  host_boot_loader #(.WORDS(WORDS)) u0 (
    .clk(clk), .rst(rst), .hb_wr(hb_wr), .hb_sel(hb_sel), .hb_data(hb_data),
    .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata), .core_run(core_run),
    .start_addr(start_addr), .mode_out(mode_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: one byte write per call, pushes expected memory writes
  task automatic put_byte(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    if (sel == 2'd1) exp_hi = d;
    if (sel == 2'd2) exp_mid = d;
    if (sel == 2'd3 && !exp_run) begin
      sb_q.push_back({AW'(exp_addr), exp_hi, exp_mid, d});
      exp_addr++;
      if (exp_addr == WORDS) exp_run = 1'b1;
    end
    hb_wr = 1'b1; hb_sel = sel; hb_data = d;
    @(negedge clk);
    hb_wr = 1'b0;
  endtask

  task automatic put_word(input logic [23:0] w);
    put_byte(2'd1, w[23:16]);
    put_byte(2'd2, w[15:8]);
    put_byte(2'd3, w[7:0]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_addr = 0; exp_run = 1'b0; exp_hi = 8'd0; exp_mid = 8'd0;
    #1;
    check(!core_run && start_addr == 0 && mode_out == 0 && pm_addr == 0, "R2 reset state",
          {core_run, start_addr, mode_out}, 0);
  endtask

  // monitor: compares every memory write with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!rst && pm_we) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R6 unexpected pm_we", int'(pm_addr), -1);
        end else begin
          logic [AW+23:0] e;
          e = sb_q.pop_front();
          check({pm_addr, pm_wdata} == e, "R1 R7 word/address", int'({pm_addr, pm_wdata}), int'(e));
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // phase A: partial load then early release
    for (int i = 0; i < 5; i++) put_word(24'h1A0000 + 24'(i * 24'h010203));
    put_byte(2'd3, 8'h77);                 // R7 staging persists
    @(negedge clk); #1;
    check(sb_q.size() == 0, "R1 all words written", sb_q.size(), 0);
    check(!core_run, "R3 not yet running", core_run, 0);
    put_byte(2'd0, 8'hF7);                 // R5 flag bit 3 clear
    #1;
    check(!core_run && mode_out == 0, "R5 flag clear ignored", core_run, 0);
    put_byte(2'd0, 8'h08);                 // R5 release flag
    exp_run = 1'b1;
    #1;
    check(core_run == 1'b1, "R5 early release", core_run, 1);
    check(start_addr == 6, "R4 start addr partial", start_addr, 6);
    check(mode_out == 3'd2, "R4 mode value", mode_out, 2);
    put_word(24'hDEAD55);                  // R6 no write
    put_byte(2'd0, 8'h08);
    repeat (4) @(negedge clk);
    #1;
    check(core_run && start_addr == 6 && mode_out == 2, "R8 sticky run",
          {core_run, start_addr}, {1'b1, 5'd6});
    // phase B: full image
    do_reset();
    for (int i = 0; i < WORDS - 1; i++) put_word(24'h300000 ^ 24'(i * 24'h0B0D11));
    #1;
    check(!core_run, "R3 one word short", core_run, 0);
    put_word(24'hFEDCBA);
    #1;
    check(core_run == 1'b1, "R3 release at WORDS", core_run, 1);
    check(start_addr == WORDS, "R4 start addr full", start_addr, WORDS);
    check(mode_out == 3'd2, "R4 mode full", mode_out, 2);
    put_word(24'h123456);                  // R6
    repeat (3) @(negedge clk);
    #1;
    check(sb_q.size() == 0, "R6 queue drained", sb_q.size(), 0);
    check(core_run && start_addr == WORDS, "R8 run held", core_run, 1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule